// File: doc/BRIEF.md
# Transmit Clock Activity Mode Detector

This block watches one transmit channel's clock and its negative-rail data input and works out which transmit mode the channel is in, purely from how long those pins stay static. All inputs are brought into one fast sampling clock domain through two-flop synchronizers. Rising edges of a free-running master clock act as the counting tick. A transmit clock stuck high for long enough selects the all-ones mode. A transmit clock stuck low for longer selects power-down, and the driver enable drops. A negative-rail input held high across enough transmit-clock falling edges selects single-rail operation.

In the all-ones mode the block produces its own alternating-polarity mark stream, paced by the counting tick and not by the dead transmit clock. When the master clock stops, a loss watchdog marks it absent. From then on, rising edges of a reference channel's clock drive the same hold-time tests. The block produces only mode flags, an enable and the pulse stream. It has no receive-side logic, so the transmit-clock state cannot reach a receive path.

Top module: `tx_mode_detect`

## Requirements
- R1: After reset the mode is normal (`mode` = 0), `drv_en` = 1, `single_rail` = 0, `all_ones` = 0, `pwr_down` = 0, `ao_pos` = `ao_neg` = 0 and `mclk_ok` = 1.
- R2: With the transmit clock held high, `all_ones` is asserted and `mode` = 1 once 16 counting ticks have passed since its last edge. After 15 ticks the mode is still normal.
- R3: With the transmit clock held low, `pwr_down` is asserted, `mode` = 2 and `drv_en` = 0 once 64 counting ticks have passed. After 63 ticks the mode is still normal and `drv_en` = 1.
- R4: Any edge on the transmit clock restarts its hold counter. The mode is back to normal (`drv_en` = 1) within one counting tick period after toggling resumes.
- R5: In all-ones mode exactly one of `ao_pos`/`ao_neg` is high, and the active one swaps on every counting tick.
- R6: `single_rail` rises after the negative-rail input has been high across 17 transmit-clock falling edges, but not after 16. Once set, it stays set until reset.
- R7: A low level on the negative-rail input clears its hold count, so the 17 edges must all be consecutive.
- R8: If no master-clock rising edge is seen for 64 sampling cycles, `mclk_ok` drops and rising edges of `ref_clk_in` become the counting tick. The next master-clock rising edge sets `mclk_ok` again.
- R9: Outside all-ones mode `ao_pos` and `ao_neg` are both 0, and `all_ones` and `pwr_down` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_in | input | 1 | Free-running master clock, asynchronous |
| tclk_in | input | 1 | Monitored transmit clock, asynchronous |
| ref_clk_in | input | 1 | Reference channel clock used when the master clock is lost |
| tdn_in | input | 1 | Negative-rail transmit data |
| mode | output | 2 | 0 normal, 1 all-ones, 2 power-down |
| all_ones | output | 1 | All-ones mode flag |
| pwr_down | output | 1 | Power-down flag |
| drv_en | output | 1 | Line driver enable, low means high-Z |
| single_rail | output | 1 | Single-rail selection, sticky |
| ao_pos | output | 1 | All-ones positive mark |
| ao_neg | output | 1 | All-ones negative mark |
| mclk_ok | output | 1 | Master clock present |

## Verification
On every cycle the assertions check several invariants. The mark outputs are never both high. A mode can only be entered after the hold counter has reached that mode's threshold at the right level. A transmit-clock edge always empties the counter, single-rail never clears by itself, and a master-clock edge always restores `mclk_ok`. The exact thresholds can only be shown by the bench's scenarios: that 15 ticks are not enough and 16 are, and likewise 63 against 64 and 16 against 17. The same holds for the switch to reference-clock counting and for the alternation of marks across a run of ticks.

// File: rtl/tmd_pkg.sv
package tmd_pkg;
  typedef enum logic [1:0] {
    TXM_NORMAL  = 2'd0,
    TXM_ALLONES = 2'd1,
    TXM_PWRDN   = 2'd2
  } txm_e;

  // Mode decision from the level the clock is stuck at and the hold length.
  function automatic txm_e judge_mode(input logic lvl, input int unsigned run,
                                      input int unsigned hi_lim, input int unsigned lo_lim);
    if (lvl && run >= hi_lim) return TXM_ALLONES;
    if (!lvl && run >= lo_lim) return TXM_PWRDN;
    return TXM_NORMAL;
  endfunction

  // Saturating increment.
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned cap);
    return (v >= cap) ? cap : v + 1;
  endfunction
endpackage

// File: rtl/tmd_sync.sv
module tmd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tmd_run_counter.sv
module tmd_run_counter
  import tmd_pkg::*;
#(
  parameter int CAP = 64,
  parameter int CW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= CW'(sat_step(32'(cnt), CAP));
  end
endmodule

// File: rtl/tmd_clk_watch.sv
module tmd_clk_watch #(
  parameter int LOSS_LIM = 64,
  parameter int GW       = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic ok
);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0;
      ok  <= 1'b1;
    end else if (rise) begin
      gap <= '0;
      ok  <= 1'b1;
    end else begin
      if (32'(gap) < LOSS_LIM) gap <= gap + 1'b1;
      if (32'(gap) >= LOSS_LIM - 1) ok <= 1'b0;
    end
  end
endmodule

// File: rtl/tmd_ami_gen.sv
module tmd_ami_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic pos,
  output logic neg
);
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= 1'b0;
    else if (!en)     phase <= 1'b0;
    else if (tick)    phase <= ~phase;
  end

  assign pos = en & phase;
  assign neg = en & ~phase;
endmodule

// File: rtl/tx_mode_detect.sv
module tx_mode_detect
  import tmd_pkg::*;
#(
  parameter int HI_LIM   = 16,
  parameter int LO_LIM   = 64,
  parameter int SR_LIM   = 16,
  parameter int LOSS_LIM = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_in,
  input  logic       tclk_in,
  input  logic       ref_clk_in,
  input  logic       tdn_in,
  output logic [1:0] mode,
  output logic       all_ones,
  output logic       pwr_down,
  output logic       drv_en,
  output logic       single_rail,
  output logic       ao_pos,
  output logic       ao_neg,
  output logic       mclk_ok
);
  localparam int RUN_CAP = (LO_LIM > HI_LIM) ? LO_LIM : HI_LIM;
  localparam int RUN_W   = $clog2(RUN_CAP + 1);
  localparam int SR_CAP  = SR_LIM + 1;
  localparam int SR_W    = $clog2(SR_CAP + 1);
  localparam int GAP_W   = $clog2(LOSS_LIM + 1);

  // bit 0 mclk, 1 tclk, 2 tdn, 3 ref
  logic [3:0] raw, syn, prv;
  assign raw = {ref_clk_in, tdn_in, tclk_in, mclk_in};

  tmd_sync #(.W(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prv <= '0;
    else        prv <= syn;
  end

  // Named events for the checker
  logic mclk_rise, ref_rise, tclk_edge, tclk_fall, run_lvl, cnt_tick, tdn_hi;
  assign mclk_rise = syn[0] & ~prv[0];
  assign ref_rise  = syn[3] & ~prv[3];
  assign tclk_edge = syn[1] ^ prv[1];
  assign tclk_fall = prv[1] & ~syn[1];
  assign run_lvl   = prv[1];
  assign tdn_hi    = syn[2];

  tmd_clk_watch #(.LOSS_LIM(LOSS_LIM), .GW(GAP_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .rise(mclk_rise), .ok(mclk_ok)
  );

  assign cnt_tick = mclk_rise | (~mclk_ok & ref_rise);

  logic [RUN_W-1:0] run_cnt;
  tmd_run_counter #(.CAP(RUN_CAP), .CW(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(tclk_edge), .inc(cnt_tick), .cnt(run_cnt)
  );

  logic [SR_W-1:0] sr_cnt;
  tmd_run_counter #(.CAP(SR_CAP), .CW(SR_W)) u_srcnt (
    .clk(clk), .rst_n(rst_n), .clr(~tdn_hi), .inc(tclk_fall), .cnt(sr_cnt)
  );

  txm_e mode_q;
  logic sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= TXM_NORMAL;
      sr_q   <= 1'b0;
    end else begin
      mode_q <= judge_mode(run_lvl, 32'(run_cnt), HI_LIM, LO_LIM);
      if (32'(sr_cnt) > SR_LIM) sr_q <= 1'b1;
    end
  end

  assign mode        = mode_q;
  assign all_ones    = (mode_q == TXM_ALLONES);
  assign pwr_down    = (mode_q == TXM_PWRDN);
  assign drv_en      = ~pwr_down;
  assign single_rail = sr_q;

  tmd_ami_gen u_ami (
    .clk(clk), .rst_n(rst_n), .en(all_ones), .tick(cnt_tick),
    .pos(ao_pos), .neg(ao_neg)
  );
endmodule

// File: rtl/tx_mode_detect_chk.sv
module tx_mode_detect_chk #(
  parameter int HI_LIM = 16,
  parameter int LO_LIM = 64,
  parameter int RUN_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             all_ones,
  input logic             pwr_down,
  input logic             single_rail,
  input logic             ao_pos,
  input logic             ao_neg,
  input logic             mclk_ok,
  input logic             mclk_rise,
  input logic             tclk_edge,
  input logic             cnt_tick,
  input logic             run_lvl,
  input logic [RUN_W-1:0] run_cnt
);
  p_ao_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ao_pos, ao_neg}));

  p_ao_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (all_ones && $past(all_ones) && $past(cnt_tick)) |-> (ao_pos != $past(ao_pos)));

  p_ao_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (all_ones && $past(all_ones) && !$past(cnt_tick)) |-> $stable(ao_pos));

  p_ao_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ones |-> !(ao_pos || ao_neg));

  p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(all_ones && pwr_down));

  p_allones_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_ones) |-> ($past(run_lvl) && 32'($past(run_cnt)) >= HI_LIM));

  p_pwrdn_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> (!$past(run_lvl) && 32'($past(run_cnt)) >= LO_LIM));

  p_edge_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_edge |=> (run_cnt == '0));

  p_sr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    single_rail |=> single_rail);

  p_mclk_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |=> mclk_ok);
endmodule

bind tx_mode_detect tx_mode_detect_chk #(
  .HI_LIM(HI_LIM), .LO_LIM(LO_LIM), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .all_ones(all_ones), .pwr_down(pwr_down),
  .single_rail(single_rail), .ao_pos(ao_pos), .ao_neg(ao_neg),
  .mclk_ok(mclk_ok), .mclk_rise(mclk_rise), .tclk_edge(tclk_edge),
  .cnt_tick(cnt_tick), .run_lvl(run_lvl), .run_cnt(run_cnt)
);

// File: tb/sim_tx_mode_detect.sv
`timescale 1ns/1ps
module sim_tx_mode_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_in = 1'b0, tclk_in = 1'b0, ref_clk_in = 1'b0, tdn_in = 1'b0;
  logic [1:0] mode;
  logic all_ones, pwr_down, drv_en, single_rail, ao_pos, ao_neg, mclk_ok;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tx_mode_detect u0 (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .tclk_in(tclk_in),
    .ref_clk_in(ref_clk_in), .tdn_in(tdn_in), .mode(mode), .all_ones(all_ones),
    .pwr_down(pwr_down), .drv_en(drv_en), .single_rail(single_rail),
    .ao_pos(ao_pos), .ao_neg(ao_neg), .mclk_ok(mclk_ok)
  );

  // Expected mode from the requirement thresholds (R2, R3)
  function automatic logic [1:0] want_mode(input logic lvl, input int held);
    if (lvl) return (held >= 16) ? 2'd1 : 2'd0;
    return (held >= 64) ? 2'd2 : 2'd0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mtick(input int n);
    for (int i = 0; i < n; i++) begin
      mclk_in = 1'b1; idle(4);
      mclk_in = 1'b0; idle(4);
    end
  endtask

  task automatic rtick(input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk_in = 1'b1; idle(4);
      ref_clk_in = 1'b0; idle(4);
    end
  endtask

  task automatic tcyc(input int n);
    for (int i = 0; i < n; i++) begin
      tclk_in = 1'b1; idle(4);
      tclk_in = 1'b0; idle(4);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mclk_in = 1'b0; tclk_in = 1'b0; ref_clk_in = 1'b0; tdn_in = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic set_tclk(input logic lvl);
    tclk_in = ~lvl; idle(6);
    tclk_in = lvl;  idle(6);
  endtask

  initial begin
    logic prev_pos;
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 drv_en", drv_en, 1);
    chk("R1 single_rail", single_rail, 0);
    chk("R1 marks", {ao_pos, ao_neg}, 0);
    chk("R1 mclk_ok", mclk_ok, 1);

    // R2 high hold threshold
    set_tclk(1'b1);
    mtick(15); idle(3);
    chk("R2 15 ticks", mode, 0);
    mtick(1); idle(3);
    chk("R2 16 ticks", mode, 1);
    chk("R2 all_ones", all_ones, 1);

    // R5 alternating marks
    prev_pos = ao_pos;
    for (int i = 0; i < 6; i++) begin
      mtick(1); idle(2);
      chk("R5 one mark", 32'(ao_pos) + 32'(ao_neg), 1);
      chk("R5 swap", ao_pos, 32'(!prev_pos));
      prev_pos = ao_pos;
    end

    // R4 return from all-ones
    tclk_in = 1'b0; idle(6);
    chk("R4 back normal", mode, 0);
    chk("R9 marks idle", {ao_pos, ao_neg}, 0);

    // R3 low hold threshold
    set_tclk(1'b0);
    mtick(63); idle(3);
    chk("R3 63 ticks", mode, 0);
    chk("R3 drv_en kept", drv_en, 1);
    mtick(1); idle(3);
    chk("R3 64 ticks", mode, 2);
    chk("R3 drv_en off", drv_en, 0);
    tclk_in = 1'b1; idle(6);
    chk("R4 wake", drv_en, 1);
    chk("R4 wake mode", mode, 0);

    // Random holds against the bench model (R2, R3, R4)
    for (int k = 0; k < 24; k++) begin
      logic lvl;
      int n;
      lvl = 1'($urandom % 2);
      n = int'($urandom % 72);
      if (k == 0) begin lvl = 1'b1; n = 16; end
      if (k == 1) begin lvl = 1'b0; n = 64; end
      set_tclk(lvl);
      mtick(n); idle(3);
      chk(lvl ? "R2 random" : "R3 random", mode, 32'(want_mode(lvl, n)));
      chk("R9 exclusive", 32'(all_ones) + 32'(pwr_down) <= 1, 1);
    end

    // R8 master clock loss and fallback to reference clock
    set_tclk(1'b1);
    idle(80);
    chk("R8 lost", mclk_ok, 0);
    chk("R8 no count", mode, 0);
    rtick(15); idle(3);
    chk("R8 ref 15", mode, 0);
    rtick(1); idle(3);
    chk("R8 ref 16", mode, 1);
    mtick(1); idle(2);
    chk("R8 back", mclk_ok, 1);

    // R6 single-rail threshold and stickiness
    do_reset();
    tdn_in = 1'b1; idle(6);
    tcyc(16); idle(4);
    chk("R6 16 edges", single_rail, 0);
    tcyc(1); idle(4);
    chk("R6 17 edges", single_rail, 1);
    tdn_in = 1'b0; idle(6); tcyc(2); idle(4);
    chk("R6 sticky", single_rail, 1);

    // R7 a low level clears the count
    do_reset();
    tdn_in = 1'b1; idle(6);
    tcyc(10); idle(2);
    tdn_in = 1'b0; idle(6);
    tdn_in = 1'b1; idle(6);
    tcyc(16); idle(4);
    chk("R7 restart", single_rail, 0);
    tcyc(1); idle(4);
    chk("R7 then set", single_rail, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule